// File: doc/BRIEF.md
# PHY Management Register Model

This block lets a host reach the management registers of a modelled Ethernet PHY through two 32-bit host registers. The command register holds the target PHY address, the register number and one bit each for read and write. The data register holds write data in its low half and returns read data in its high half. A command runs for a fixed, parameterised number of cycles. While it runs, `busy` is high. When it ends, the command bits clear themselves.

The PHY side is a sparse space of 32 registers, each 16 bits wide. It holds the basic control, basic status, two identifier words, the autonegotiation advertisement, an interrupt enable and an interrupt status. Autonegotiation is treated as finishing at once. A `link_up` input drives the status bits and raises interrupt events. `phy_irq` reports any pending event that is enabled. Addresses without a modelled register read as zero.

Top module: `phy_mgmt_model`

## Requirements
- R1: After reset, `cmd_reg`, `data_reg`, `busy` and `phy_irq` are zero. Register 0 (control) reads 0x1140, register 1 (status, link up) reads 0x796D and register 4 (advertisement) reads 0x0DE1.
- R2: The command register holds the PHY address in bits 20:16, the register number in 25:21, the read request in bit 26 and the write request in bit 27. An idle host write stores all 32 bits. Only a write with bit 26 or bit 27 set starts an access.
- R3: `busy` rises on the cycle after the command write that starts an access. It stays high for exactly ACCESS_CYCLES cycles. When it falls, bits 27:26 are zero and the other command bits keep their values.
- R4: A host write to the data register stores bits 15:0 and zeroes bits 31:16. A write access sends data bits 15:0 to the PHY register and leaves the data register unchanged. A read access loads the result into bits 31:16 and zeroes bits 15:0.
- R5: While `busy` is high, host writes to either register are ignored.
- R6: When bits 26 and 27 are both set, only the write is performed.
- R7: An access whose address differs from PHY_ADDR returns 0xFFFF as read data and changes no PHY register, including the interrupt status.
- R8: Writing register 0 with bit 15 set restores the reset values of control, status and advertisement, and clears the interrupt enable and status. The status keeps link-up (bit 2) and autonegotiation-done (bit 5) clear while the link is down. Without bit 15, the value is stored masked with 0x7980. Bit 12 set also sets status bit 5.
- R9: A write to register 4 stores (value AND 0x2D7F) OR 0x0080.
- R10: Registers 2 and 3 return PHY_ID_HI and PHY_ID_LO. Registers 1, 2 and 3 ignore writes. Every other register not named here reads zero and ignores writes.
- R11: Register 18 keeps only bits 7:0 of a write. Register 19 returns the pending events and clears them on that read.
- R12: On a sampled fall of `link_up`, status bits 2 and 5 clear and event bit 8 is set. On a sampled rise, both status bits set and event bit 11 is set.
- R13: `phy_irq` is high whenever event bits 15:8 AND enable bits 7:0 is nonzero. It is updated on the same edge as those registers.
- R14: If a link event and a read of register 19 fall on the same edge, the read returns the events pending before that edge. The new event bit survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_sel | input | 1 | 0 selects the command register, 1 the data register |
| host_wdata | input | 32 | Host write value |
| link_up | input | 1 | Current link state |
| cmd_reg | output | 32 | Command register contents |
| data_reg | output | 32 | Data register contents |
| busy | output | 1 | Access in progress |
| phy_irq | output | 1 | Enabled PHY event pending |

## Verification
Two things can land on one clock edge: the clear-on-read of the event register at the end of an access, and a link transition sampled by the PHY model. The bench starts a read of register 19 and counts out the fixed access latency. It then toggles `link_up` so that the transition is sampled on the very edge where the access completes. It checks that the returned data is the old event set (empty). A second read must then show the bit for the new event. The status bits must match the new link state.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int unsigned PHY_REG_W = 16;
  localparam int unsigned PHY_IDX_W = 5;
  localparam int unsigned IRQ_EN_W  = 8;

  // command register field positions
  localparam int unsigned CMD_ADDR_LSB = 16;
  localparam int unsigned CMD_REG_LSB  = 21;
  localparam int unsigned CMD_RD_B     = 26;
  localparam int unsigned CMD_WR_B     = 27;

  // modelled PHY register numbers
  localparam logic [PHY_IDX_W-1:0] RG_CTRL   = 5'd0;
  localparam logic [PHY_IDX_W-1:0] RG_STAT   = 5'd1;
  localparam logic [PHY_IDX_W-1:0] RG_ID_HI  = 5'd2;
  localparam logic [PHY_IDX_W-1:0] RG_ID_LO  = 5'd3;
  localparam logic [PHY_IDX_W-1:0] RG_ADV    = 5'd4;
  localparam logic [PHY_IDX_W-1:0] RG_IRQ_EN = 5'd18;
  localparam logic [PHY_IDX_W-1:0] RG_IRQ_ST = 5'd19;

  // reset values and write masks
  localparam logic [PHY_REG_W-1:0] CTRL_INIT = 16'h1140;
  localparam logic [PHY_REG_W-1:0] CTRL_KEEP = 16'h7980;
  localparam logic [PHY_REG_W-1:0] STAT_INIT = 16'h796D;
  localparam logic [PHY_REG_W-1:0] ADV_INIT  = 16'h0DE1;
  localparam logic [PHY_REG_W-1:0] ADV_KEEP  = 16'h2D7F;
  localparam logic [PHY_REG_W-1:0] ADV_FORCE = 16'h0080;

  // bit positions with behavioural meaning
  localparam int unsigned CTRL_SOFT_RST_B = 15;
  localparam int unsigned CTRL_AN_EN_B    = 12;
  localparam int unsigned STAT_LINK_B     = 2;
  localparam int unsigned STAT_AN_DONE_B  = 5;
  localparam int unsigned EVT_DOWN_B      = 8;
  localparam int unsigned EVT_UP_B        = 11;
  localparam int unsigned EVT_GATED_LSB   = 8;

  typedef struct packed {
    logic                 go;
    logic                 wr;
    logic [PHY_IDX_W-1:0] regno;
    logic [PHY_REG_W-1:0] wdata;
  } phy_req_t;

endpackage

// File: rtl/phy_mgmt_seq.sv
module phy_mgmt_seq
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned          ACCESS_CYCLES = 4,
  parameter logic [PHY_IDX_W-1:0] PHY_ADDR      = 5'd1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_wr,
  input  logic                 host_sel,
  input  logic [31:0]          host_wdata,
  input  logic [PHY_REG_W-1:0] rd_val,
  output phy_req_t             req,
  output logic [31:0]          cmd_q,
  output logic [31:0]          data_q,
  output logic                 busy_q
);

  localparam int unsigned CW = (ACCESS_CYCLES < 2) ? 1 : $clog2(ACCESS_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACCESS_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done;
  logic          hit;
  logic          is_wr;

  assign done  = busy_q && (cnt_q == '0);
  assign hit   = (cmd_q[CMD_ADDR_LSB +: PHY_IDX_W] == PHY_ADDR);
  assign is_wr = cmd_q[CMD_WR_B];

  always_comb begin
    req.go    = done && hit;
    req.wr    = is_wr;
    req.regno = cmd_q[CMD_REG_LSB +: PHY_IDX_W];
    req.wdata = data_q[PHY_REG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (done) begin
      busy_q              <= 1'b0;
      cmd_q[CMD_WR_B]     <= 1'b0;
      cmd_q[CMD_RD_B]     <= 1'b0;
      if (!is_wr)
        data_q <= {(hit ? rd_val : {PHY_REG_W{1'b1}}), 16'h0000};
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (host_wr) begin
      if (!host_sel) begin
        cmd_q <= host_wdata;
        if (host_wdata[CMD_WR_B] || host_wdata[CMD_RD_B]) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_LOAD;
        end
      end else begin
        data_q <= {16'h0000, host_wdata[15:0]};
      end
    end
  end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [PHY_REG_W-1:0] PHY_ID_HI = 16'h001C,
  parameter logic [PHY_REG_W-1:0] PHY_ID_LO = 16'hC916
) (
  input  logic                 clk,
  input  logic                 rst,
  input  phy_req_t             req,
  input  logic                 link_up,
  output logic [PHY_REG_W-1:0] rd_val,
  output logic                 phy_irq
);

  logic [PHY_REG_W-1:0] ctrl_q, stat_q, adv_q, evt_q;
  logic [IRQ_EN_W-1:0]  ien_q;
  logic [PHY_REG_W-1:0] ctrl_d, stat_d, adv_d, evt_d;
  logic [IRQ_EN_W-1:0]  ien_d;
  logic                 link_q;

  always_comb begin
    case (req.regno)
      RG_CTRL:   rd_val = ctrl_q;
      RG_STAT:   rd_val = stat_q;
      RG_ID_HI:  rd_val = PHY_ID_HI;
      RG_ID_LO:  rd_val = PHY_ID_LO;
      RG_ADV:    rd_val = adv_q;
      RG_IRQ_EN: rd_val = {{(PHY_REG_W-IRQ_EN_W){1'b0}}, ien_q};
      RG_IRQ_ST: rd_val = evt_q;
      default:   rd_val = '0;
    endcase
  end

  always_comb begin
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    adv_d  = adv_q;
    ien_d  = ien_q;
    evt_d  = evt_q;
    // host access first
    if (req.go) begin
      if (req.wr) begin
        case (req.regno)
          RG_CTRL: begin
            if (req.wdata[CTRL_SOFT_RST_B]) begin
              ctrl_d = CTRL_INIT;
              stat_d = STAT_INIT;
              if (!link_q) begin
                stat_d[STAT_LINK_B]    = 1'b0;
                stat_d[STAT_AN_DONE_B] = 1'b0;
              end
              adv_d = ADV_INIT;
              ien_d = '0;
              evt_d = '0;
            end else begin
              ctrl_d = req.wdata & CTRL_KEEP;
              if (req.wdata[CTRL_AN_EN_B])
                stat_d[STAT_AN_DONE_B] = 1'b1;
            end
          end
          RG_ADV:    adv_d = (req.wdata & ADV_KEEP) | ADV_FORCE;
          RG_IRQ_EN: ien_d = req.wdata[IRQ_EN_W-1:0];
          default:   ;
        endcase
      end else if (req.regno == RG_IRQ_ST) begin
        evt_d = '0;
      end
    end
    // link events applied last so they survive a clear on the same edge
    if (link_up != link_q) begin
      stat_d[STAT_LINK_B]    = link_up;
      stat_d[STAT_AN_DONE_B] = link_up;
      if (link_up) evt_d[EVT_UP_B]   = 1'b1;
      else         evt_d[EVT_DOWN_B] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_INIT;
      stat_q  <= STAT_INIT;
      adv_q   <= ADV_INIT;
      ien_q   <= '0;
      evt_q   <= '0;
      link_q  <= 1'b1;
      phy_irq <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      stat_q  <= stat_d;
      adv_q   <= adv_d;
      ien_q   <= ien_d;
      evt_q   <= evt_d;
      link_q  <= link_up;
      phy_irq <= |(evt_d[EVT_GATED_LSB +: IRQ_EN_W] & ien_d);
    end
  end

endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned          ACCESS_CYCLES = 4,
  parameter logic [PHY_IDX_W-1:0] PHY_ADDR      = 5'd1,
  parameter logic [PHY_REG_W-1:0] PHY_ID_HI     = 16'h001C,
  parameter logic [PHY_REG_W-1:0] PHY_ID_LO     = 16'hC916
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_sel,
  input  logic [31:0] host_wdata,
  input  logic        link_up,
  output logic [31:0] cmd_reg,
  output logic [31:0] data_reg,
  output logic        busy,
  output logic        phy_irq
);

  phy_req_t             req;
  logic [PHY_REG_W-1:0] rd_val;

  phy_mgmt_seq #(
    .ACCESS_CYCLES (ACCESS_CYCLES),
    .PHY_ADDR      (PHY_ADDR)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .rd_val     (rd_val),
    .req        (req),
    .cmd_q      (cmd_reg),
    .data_q     (data_reg),
    .busy_q     (busy)
  );

  phy_mgmt_regs #(
    .PHY_ID_HI (PHY_ID_HI),
    .PHY_ID_LO (PHY_ID_LO)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .link_up (link_up),
    .rd_val  (rd_val),
    .phy_irq (phy_irq)
  );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
  parameter int unsigned ACCESS_CYCLES = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        host_wr,
  input logic        host_sel,
  input logic [31:0] host_wdata,
  input logic [31:0] cmd_reg,
  input logic        busy
);

  logic [15:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_busy_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(host_wr && !host_sel && (host_wdata[27:26] != 2'b00)));

  assert_bits_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (cmd_reg[27:26] == 2'b00));

  assert_busy_bits_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cmd_reg[27:26] != 2'b00));

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_q == 16'(ACCESS_CYCLES)));

  assert_busy_max_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < 16'(ACCESS_CYCLES)));

  assert_cmd_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr && !host_sel) |=> (cmd_reg[25:16] == $past(cmd_reg[25:16])));

endmodule

bind phy_mgmt_model phy_mgmt_chk #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wr    (host_wr),
  .host_sel   (host_sel),
  .host_wdata (host_wdata),
  .cmd_reg    (cmd_reg),
  .busy       (busy)
);

// File: tb/phy_mgmt_model_tb.sv
module phy_mgmt_model_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [4:0] PA = 5'd1;
  localparam logic [15:0] IDH = 16'h001C;
  localparam logic [15:0] IDL = 16'hC916;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic link_up = 1'b1;
  logic [31:0] cmd_reg, data_reg;
  logic busy, phy_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_model #(.ACCESS_CYCLES(N), .PHY_ADDR(PA), .PHY_ID_HI(IDH), .PHY_ID_LO(IDL)) u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .link_up(link_up), .cmd_reg(cmd_reg), .data_reg(data_reg), .busy(busy), .phy_irq(phy_irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [31:0] v);
    @(negedge clk); host_wr = 1'b1; host_sel = 1'b0; host_wdata = v;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [31:0] v);
    @(negedge clk); host_wr = 1'b1; host_sel = 1'b1; host_wdata = v;
    @(negedge clk); host_wr = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(input bit w, input bit r, input logic [4:0] rg, input logic [4:0] ad);
    return {4'b0, w, r, rg, ad, 16'h0000};
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic phy_rd(input logic [4:0] ad, input logic [4:0] rg, output logic [15:0] rv);
    wr_cmd(mk_cmd(0, 1, rg, ad));
    wait_idle();
    rv = data_reg[31:16];
  endtask

  task automatic phy_wr(input logic [4:0] ad, input logic [4:0] rg, input logic [15:0] wd);
    wr_data({16'h0, wd});
    wr_cmd(mk_cmd(1, 0, rg, ad));
    wait_idle();
  endtask

  task automatic set_link(input logic v);
    @(negedge clk); link_up = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] reset_val(input int r);
    case (r)
      0: return 16'h1140;
      1: return 16'h796D;
      2: return IDH;
      3: return IDL;
      4: return 16'h0DE1;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] rv;
    int cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state of host side
    check("R1 cmd_reg", cmd_reg, 32'h0);
    check("R1 data_reg", data_reg, 32'h0);
    check("R1 busy", {31'h0, busy}, 32'h0);
    check("R1 phy_irq", {31'h0, phy_irq}, 32'h0);

    // R2 command without request bits does not start an access
    wr_cmd(32'h03E1_1234);
    check("R2 stored", cmd_reg, 32'h03E1_1234);
    check("R2 no busy", {31'h0, busy}, 32'h0);

    // R3 exact busy length, field preservation, R1 control reset value
    wr_cmd(mk_cmd(0, 1, 5'd0, PA));
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R3 busy length", cnt, N);
    check("R3 cmd after", cmd_reg, mk_cmd(0, 0, 5'd0, PA));
    check("R1 R4 ctrl read", data_reg, {16'h1140, 16'h0000});

    // R1 R10 sweep of all registers at reset
    for (int r = 0; r < 32; r++) begin
      phy_rd(PA, 5'(r), rv);
      check($sformatf("R10 reset read reg%0d", r), {16'h0, rv}, {16'h0, reset_val(r)});
    end

    // R4 data register write
    wr_data(32'hABCD_1234);
    check("R4 data store", data_reg, 32'h0000_1234);

    // R9 advertisement sweep
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v;
      v = 16'(i * 16'h1111) ^ 16'hA5C3;
      phy_wr(PA, 5'd4, v);
      check("R4 write keeps data", data_reg, {16'h0, v});
      phy_rd(PA, 5'd4, rv);
      check($sformatf("R9 adv 0x%04h", v), {16'h0, rv}, {16'h0, (v & 16'h2D7F) | 16'h0080});
    end

    // R12 link down
    set_link(1'b0);
    phy_rd(PA, 5'd1, rv);
    check("R12 stat down", {16'h0, rv}, 32'h7949);
    phy_rd(PA, 5'd19, rv);
    check("R12 evt down", {16'h0, rv}, 32'h0100);
    phy_rd(PA, 5'd19, rv);
    check("R11 clear on read", {16'h0, rv}, 32'h0);

    // R8 control writes
    phy_wr(PA, 5'd0, 16'h1000);
    phy_rd(PA, 5'd0, rv);
    check("R8 ctrl an", {16'h0, rv}, 32'h1000);
    phy_rd(PA, 5'd1, rv);
    check("R8 an done set", {16'h0, rv}, 32'h7969);
    phy_wr(PA, 5'd0, 16'h7FFF);
    phy_rd(PA, 5'd0, rv);
    check("R8 ctrl mask", {16'h0, rv}, 32'h7980);
    phy_wr(PA, 5'd18, 16'h00AA);
    phy_wr(PA, 5'd0, 16'h8000);
    phy_rd(PA, 5'd0, rv);
    check("R8 soft reset ctrl", {16'h0, rv}, 32'h1140);
    phy_rd(PA, 5'd4, rv);
    check("R8 soft reset adv", {16'h0, rv}, 32'h0DE1);
    phy_rd(PA, 5'd1, rv);
    check("R8 soft reset stat link down", {16'h0, rv}, 32'h7949);
    phy_rd(PA, 5'd18, rv);
    check("R8 soft reset enable", {16'h0, rv}, 32'h0);

    // R12 link up
    set_link(1'b1);
    phy_rd(PA, 5'd1, rv);
    check("R12 stat up", {16'h0, rv}, 32'h796D);
    phy_rd(PA, 5'd19, rv);
    check("R12 evt up", {16'h0, rv}, 32'h0800);

    // R10 writes to read-only and unmodelled registers
    phy_wr(PA, 5'd1, 16'hFFFF);
    phy_rd(PA, 5'd1, rv);
    check("R10 stat ro", {16'h0, rv}, 32'h796D);
    phy_wr(PA, 5'd2, 16'hFFFF);
    phy_rd(PA, 5'd2, rv);
    check("R10 id ro", {16'h0, rv}, {16'h0, IDH});
    phy_wr(PA, 5'd7, 16'hFFFF);
    phy_rd(PA, 5'd7, rv);
    check("R10 unmodelled 7", {16'h0, rv}, 32'h0);
    phy_wr(PA, 5'd31, 16'hFFFF);
    phy_rd(PA, 5'd31, rv);
    check("R10 unmodelled 31", {16'h0, rv}, 32'h0);

    // R11 enable width
    phy_wr(PA, 5'd18, 16'hFFFF);
    phy_rd(PA, 5'd18, rv);
    check("R11 enable low byte", {16'h0, rv}, 32'h00FF);

    // R13 interrupt output
    phy_wr(PA, 5'd18, 16'h0001);
    check("R13 irq idle", {31'h0, phy_irq}, 32'h0);
    set_link(1'b0);
    check("R13 irq down enabled", {31'h0, phy_irq}, 32'h1);
    phy_rd(PA, 5'd19, rv);
    check("R13 irq cleared", {31'h0, phy_irq}, 32'h0);
    phy_wr(PA, 5'd18, 16'h0008);
    set_link(1'b1);
    check("R13 irq up enabled", {31'h0, phy_irq}, 32'h1);
    phy_wr(PA, 5'd18, 16'h0000);
    check("R13 irq masked", {31'h0, phy_irq}, 32'h0);
    phy_rd(PA, 5'd19, rv);
    check("R13 pending kept", {16'h0, rv}, 32'h0800);

    // R6 both request bits
    wr_data(32'h0000_0000);
    wr_cmd(mk_cmd(1, 1, 5'd4, PA));
    wait_idle();
    check("R6 data unchanged", data_reg, 32'h0);
    phy_rd(PA, 5'd4, rv);
    check("R6 write done", {16'h0, rv}, 32'h0080);

    // R7 address mismatch
    phy_rd(PA + 5'd1, 5'd0, rv);
    check("R7 mismatch read", {16'h0, rv}, 32'hFFFF);
    phy_wr(PA + 5'd1, 5'd4, 16'h2D7F);
    phy_rd(PA, 5'd4, rv);
    check("R7 mismatch write", {16'h0, rv}, 32'h0080);
    set_link(1'b0);
    phy_rd(PA + 5'd1, 5'd19, rv);
    phy_rd(PA, 5'd19, rv);
    check("R7 no clear", {16'h0, rv}, 32'h0100);

    // R5 host writes while busy
    wr_cmd(mk_cmd(0, 1, 5'd4, PA));
    wr_data(32'h0000_5555);
    wr_cmd(mk_cmd(0, 1, 5'd0, PA + 5'd2));
    wait_idle();
    check("R5 data ignored", data_reg, {16'h0080, 16'h0000});
    check("R5 cmd ignored", cmd_reg, mk_cmd(0, 0, 5'd4, PA));

    // R14 link event on the same edge as clear-on-read
    wr_cmd(mk_cmd(0, 1, 5'd19, PA));
    repeat (N - 1) @(negedge clk);
    link_up = 1'b1;
    wait_idle();
    check("R14 old events", data_reg, 32'h0);
    phy_rd(PA, 5'd19, rv);
    check("R14 new event kept", {16'h0, rv}, 32'h0800);
    phy_rd(PA, 5'd1, rv);
    check("R14 stat up", {16'h0, rv}, 32'h796D);

    finish_run();
  end

endmodule